// File: doc/BRIEF.md
# Sequential Q16.16 Neuron Engine

This block evaluates a single artificial neuron, one input per clock. A caller selects a neuron index and pulses `start`. It then streams signed fixed-point samples, each marked by `in_valid`. Each accepted sample is multiplied by the weight for that neuron and that input position, which is read from an internal weight store. The products are accumulated, the bias is added once at the end, and the sum is saturated to 32 bits. When the block is built with the activation enabled, the result then passes through a rectified-linear stage.

The weight store is a flat array of 32-bit words and has its own write port. Every neuron owns a contiguous run of `N_INPUTS` words, so one store and one engine can serve a whole layer by stepping the neuron index. Built with the activation disabled, the same engine produces raw scores for an output layer. Each product is computed at full precision, and the running sum is kept in a wide accumulator so that intermediate sums never wrap.

Top module: `q16_neuron_engine`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all 0.
- R2: A `start` pulse clears the accumulator and the input position and raises `busy` one edge later. `in_valid` is ignored while `busy` is low and in the cycle in which `start` is high. Such inputs change neither `result` nor `done`.
- R3: When started with `neuron_sel = k`, the i-th accepted input (i from 0) is multiplied by the weight word at address `k*N_INPUTS + i`. `neuron_sel` must be below `N_NEURONS`.
- R4: All data words are signed two's-complement Q16.16. Each 32x32 product is formed as a 64-bit signed value and reduced to Q16.16 by taking product bits [47:16], which is an arithmetic shift right by 16, rounding toward minus infinity.
- R5: `bias` (Q16.16) is added exactly once, after the last product. With all inputs zero, the pre-activation result equals `bias`.
- R6: The final sum saturates: above 0x7FFFFFFF it gives 0x7FFFFFFF, below 0x80000000 it gives 0x80000000, and it never wraps.
- R7: With `RELU_EN = 1`, a saturated value whose bit 31 is 1 is output as 0x00000000. Otherwise the value passes through unchanged.
- R8: With `RELU_EN = 0`, the saturated value is output unchanged, including negative values.
- R9: `busy` falls one edge after the edge that accepts input number `N_INPUTS`. `done` is high for exactly one cycle, starting two edges after that accepting edge, and it is valid together with `result`.
- R10: `result` holds its value from one `done` pulse until the next one.
- R11: Cycles with `in_valid` low during a run add nothing. Exactly one multiply-accumulate is performed for each accepted input, whatever gaps occur between inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new neuron evaluation |
| neuron_sel | input | SEL_W | Index of the neuron whose weight segment is used |
| in_valid | input | 1 | Marks `in_data` as a sample |
| in_data | input | WORD_W | Signed Q16.16 input sample |
| bias | input | WORD_W | Signed Q16.16 bias, sampled at the edge that raises `done` |
| wr_en | input | 1 | Weight store write enable |
| wr_addr | input | ADDR_W | Weight store write address |
| wr_data | input | WORD_W | Weight word to write |
| busy | output | 1 | Run in progress; inputs are accepted |
| done | output | 1 | One-cycle pulse: `result` is new |
| result | output | WORD_W | Saturated and optionally rectified Q16.16 result |

## Verification
The last accepted sample is registered together with its weight read at one edge. It reaches the accumulator at the next edge, and the edge after that writes `result` and raises `done`. The bench therefore changes inputs on falling edges only. At the falling edge after the accepting edge it expects `busy` low and `done` low. One falling edge later `done` is still low. At the falling edge after that it compares `result` and `done` against a bench model of the Q16.16 arithmetic, and one cycle later it confirms that `done` has fallen and `result` has held. Inputs applied while idle, or in the start cycle, are followed by checks that neither output moved.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_FRAC_W = 16;
  localparam int DEF_ACC_W  = 48;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/weight_store.sv
module weight_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  // one write port and one registered read port, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (32'(rd_addr) < 32'(DEPTH))); // R3
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import neuron_pkg::*;
#(
  parameter int N_INPUTS  = 4,
  parameter int N_NEURONS = 2,
  parameter int AW        = 3,
  parameter int CW        = 3,
  parameter int SW        = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] neuron_sel,
  input  logic          in_valid,
  output logic          busy,
  output logic          take,
  output logic          last_take,
  output logic [AW-1:0] rd_addr
);
  localparam logic [AW-1:0] SEG_LEN  = AW'(N_INPUTS);
  localparam logic [CW-1:0] LAST_POS = CW'(N_INPUTS - 1);

  run_state_e    state;
  logic [CW-1:0] pos;
  logic [AW-1:0] base;

  assign busy      = (state == ST_RUN);
  assign take      = busy && in_valid && !start;
  assign last_take = take && (pos == LAST_POS);
  assign rd_addr   = base + AW'(pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pos   <= '0;
      base  <= '0;
    end else if (start) begin
      state <= ST_RUN;
      pos   <= '0;
      base  <= AW'(neuron_sel) * SEG_LEN;
    end else if (take) begin
      pos <= pos + 1'b1;
      if (last_take) state <= ST_IDLE;
    end
  end

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    start |-> (32'(neuron_sel) < 32'(N_NEURONS))); // R3
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(pos)); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    last_take |=> !busy); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R2
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    take,
  input  logic                    last_take,
  input  logic [WORD_W-1:0]       x_in,
  input  logic [WORD_W-1:0]       w_rd,
  output logic signed [ACC_W-1:0] acc,
  output logic                    fin
);
  localparam int PROD_W = 2 * WORD_W;

  logic [WORD_W-1:0]        x_q;
  logic                     v_q;
  logic                     l_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [WORD_W-1:0] scaled;
  logic signed [ACC_W-1:0]  scaled_ext;

  always_comb begin
    prod       = $signed(x_q) * $signed(w_rd);
    scaled     = WORD_W'(prod >>> FRAC_W);
    scaled_ext = {{(ACC_W-WORD_W){scaled[WORD_W-1]}}, scaled};
  end

  always_ff @(posedge clk) begin
    if (take) x_q <= x_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
      v_q <= 1'b0;
      l_q <= 1'b0;
      fin <= 1'b0;
    end else begin
      v_q <= take;
      l_q <= last_take;
      fin <= v_q && l_q;
      if (v_q) acc <= acc + scaled_ext;
    end
  end

  AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == '0)); // R2
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!v_q && !clear) |=> $stable(acc)); // R11
  AST_FIN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (last_take && !clear) |=> !fin); // R9
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int WORD_W  = 32,
  parameter int ACC_W   = 48,
  parameter bit RELU_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fin,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [WORD_W-1:0]       bias,
  output logic                    done_o,
  output logic [WORD_W-1:0]       result_o
);
  localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};

  logic signed [ACC_W:0]     total;
  logic [ACC_W-WORD_W+1:0]   top_bits;
  logic                      fits;
  logic [WORD_W-1:0]         clipped;
  logic [WORD_W-1:0]         act;

  always_comb begin
    total    = {acc[ACC_W-1], acc} + {{(ACC_W-WORD_W+1){bias[WORD_W-1]}}, bias};
    top_bits = total[ACC_W:WORD_W-1];
    fits     = (&top_bits) || !(|top_bits);
    if (fits)            clipped = total[WORD_W-1:0];
    else if (total[ACC_W]) clipped = NEG_LIM;
    else                 clipped = POS_LIM;
  end

  generate
    if (RELU_EN) begin : g_relu
      assign act = clipped[WORD_W-1] ? '0 : clipped;
      AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !result_o[WORD_W-1]); // R7
    end else begin : g_raw
      assign act = clipped;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= fin;
      if (fin) result_o <= act;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(result_o)); // R10
endmodule

// File: rtl/q16_neuron_engine.sv
module q16_neuron_engine
  import neuron_pkg::*;
#(
  parameter int N_INPUTS  = 784,
  parameter int N_NEURONS = 2,
  parameter int WORD_W    = DEF_WORD_W,
  parameter int FRAC_W    = DEF_FRAC_W,
  parameter int ACC_W     = DEF_ACC_W,
  parameter bit RELU_EN   = 1'b1,
  localparam int DEPTH    = N_INPUTS * N_NEURONS,
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(N_INPUTS + 1),
  localparam int SEL_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  neuron_sel,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] bias,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  logic                    take;
  logic                    last_take;
  logic [ADDR_W-1:0]       rd_addr;
  logic [WORD_W-1:0]       w_rd;
  logic signed [ACC_W-1:0] acc;
  logic                    fin;

  seq_ctrl #(
    .N_INPUTS (N_INPUTS),
    .N_NEURONS(N_NEURONS),
    .AW       (ADDR_W),
    .CW       (CNT_W),
    .SW       (SEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .neuron_sel(neuron_sel),
    .in_valid  (in_valid),
    .busy      (busy),
    .take      (take),
    .last_take (last_take),
    .rd_addr   (rd_addr)
  );

  weight_store #(
    .WORD_W(WORD_W),
    .DEPTH (DEPTH),
    .AW    (ADDR_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (take),
    .rd_addr(rd_addr),
    .rd_data(w_rd)
  );

  mac_datapath #(
    .WORD_W(WORD_W),
    .FRAC_W(FRAC_W),
    .ACC_W (ACC_W)
  ) u_mac (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .take     (take),
    .last_take(last_take),
    .x_in     (in_data),
    .w_rd     (w_rd),
    .acc      (acc),
    .fin      (fin)
  );

  result_stage #(
    .WORD_W (WORD_W),
    .ACC_W  (ACC_W),
    .RELU_EN(RELU_EN)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .fin     (fin),
    .acc     (acc),
    .bias    (bias),
    .done_o  (done),
    .result_o(result)
  );

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
endmodule

// File: tb/q16_neuron_engine_tb.sv
module q16_neuron_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NN = 3;
  localparam int DP = NI * NN;
  localparam longint LMAX = 64'sd2147483647;
  localparam longint LMIN = -LMAX - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] neuron_sel = '0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [31:0] bias = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic busy, done, busy_r, done_r;
  logic [31:0] result, result_r;

  int n_checks = 0;
  int n_fail = 0;
  bit ended = 1'b0;
  logic [31:0] wm [DP];
  logic [31:0] xv [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  q16_neuron_engine #(.N_INPUTS(NI), .N_NEURONS(NN), .RELU_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start(start), .neuron_sel(neuron_sel),
    .in_valid(in_valid), .in_data(in_data), .bias(bias),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .result(result));

  q16_neuron_engine #(.N_INPUTS(NI), .N_NEURONS(NN), .RELU_EN(1'b0)) u_dut_raw (
    .clk(clk), .rst(rst), .start(start), .neuron_sel(neuron_sel),
    .in_valid(in_valid), .in_data(in_data), .bias(bias),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy_r), .done(done_r), .result(result_r));

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // arithmetic model: Q16.16 products floored, wide sum, bias, clip, optional rectifier
  function automatic logic [31:0] model(input int k, input logic [31:0] b, input bit relu);
    longint sum = 0;
    logic [31:0] r;
    for (int i = 0; i < NI; i++) begin
      longint p = longint'($signed(xv[i])) * longint'($signed(wm[k*NI + i]));
      longint q = p >>> 16;
      sum += longint'($signed(q[31:0]));
    end
    sum += longint'($signed(b));
    if (sum > LMAX) r = 32'h7FFF_FFFF;
    else if (sum < LMIN) r = 32'h8000_0000;
    else r = sum[31:0];
    if (relu && r[31]) r = '0;
    return r;
  endfunction

  task automatic load_w(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wm[a] = d;
  endtask

  // gaps: bit i inserts an idle cycle after input i (i < NI-1)
  task automatic run(input int k, input logic [31:0] b, input int gaps, input bit junk,
                     input string tag);
    logic [31:0] e_relu, e_raw;
    e_relu = model(k, b, 1'b1);
    e_raw  = model(k, b, 1'b0);
    @(negedge clk);
    start = 1'b1; neuron_sel = 2'(k); bias = b;
    if (junk) begin in_valid = 1'b1; in_data = 32'h0123_4567; end
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    for (int i = 0; i < NI; i++) begin
      in_valid = 1'b1; in_data = xv[i];
      @(negedge clk);
      in_valid = 1'b0;
      if (i < NI-1 && gaps[i]) @(negedge clk);
    end
    check("R9 busy low after last input", {31'd0, busy}, 32'd0);
    check("R9 done low one edge after last", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R9 done low two edges after last", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R9 done pulse", {31'd0, done}, 32'd1);
    check({tag, " relu result"}, result, e_relu);
    check({tag, " raw result"}, result_r, e_raw);
    @(negedge clk);
    check("R9 done single cycle", {31'd0, done}, 32'd0);
    check("R10 result held", result, e_relu);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    for (int j = 0; j < DP; j++) wm[j] = '0;
    for (int i = 0; i < NI; i++) xv[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 busy reset", {31'd0, busy}, 32'd0);
    check("R1 done reset", {31'd0, done}, 32'd0);
    check("R1 result reset", result, 32'd0);

    // R4: explicit rescale values on neuron 1
    for (int j = 0; j < DP; j++) load_w(j, 32'd0);
    load_w(1*NI + 0, 32'h0000_8000);
    load_w(1*NI + 1, 32'hFFFF_8000);
    xv[0] = 32'h0000_8000; xv[1] = 32'h0000_0001; xv[2] = 32'h0003_0000; xv[3] = 32'h0;
    run(1, 32'd0, 0, 1'b0, "R4 half times half plus floored tiny");
    // 0.25 = 0x4000, -2^-17 floors to -2^-16 (0xFFFFFFFF): sum 0x3FFF
    check("R4 explicit value", result_r, 32'h0000_3FFF);

    // R5: zero inputs give the bias
    for (int i = 0; i < NI; i++) xv[i] = '0;
    run(1, 32'h0003_0000, 0, 1'b0, "R5 bias only positive");
    check("R5 explicit bias", result_r, 32'h0003_0000);
    run(1, 32'hFFFD_0000, 0, 1'b0, "R5 bias only negative");
    check("R8 raw negative kept", result_r, 32'hFFFD_0000);
    check("R7 relu negative zero", result, 32'h0);

    // sweep weights and inputs over all neurons and gap patterns
    for (int j = 0; j < DP; j++) load_w(j, 32'(((j*11) % 23 - 11) * 5000 + j*37));
    for (int k = 0; k < NN; k++) begin
      for (int p = 0; p < 8; p++) begin
        for (int i = 0; i < NI; i++)
          xv[i] = 32'(((k*7 + p*13 + i*5) % 17 - 8) * 9000 + p*i*131);
        run(k, 32'((p - 3) * 20000), p, p[0], "R3 R11 sweep");
      end
    end

    // R2: inputs while idle must not touch outputs
    begin
      logic [31:0] held;
      held = result;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'h7FFF_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 idle input no done", {31'd0, done}, 32'd0);
        check("R2 idle input result unchanged", result, held);
      end
    end

    // R6: saturation in both directions on neuron 2
    for (int i = 0; i < NI; i++) load_w(2*NI + i, 32'h6000_0000);
    for (int i = 0; i < NI; i++) xv[i] = 32'h0001_0000;
    run(2, 32'd0, 0, 1'b0, "R6 positive saturation");
    check("R6 explicit positive limit", result_r, 32'h7FFF_FFFF);
    for (int i = 0; i < NI; i++) load_w(2*NI + i, 32'hA000_0000);
    run(2, 32'd0, 5, 1'b1, "R6 negative saturation");
    check("R6 explicit negative limit", result_r, 32'h8000_0000);
    check("R7 saturated negative rectified", result, 32'h0);

    // R3: neuron 0 and 2 differ only by segment
    run(0, 32'd0, 0, 1'b0, "R3 segment zero after writes");

    finish_up();
  end
endmodule